// File: doc/BRIEF.md
# Reversible BCD Decade Counter

This block is one decimal digit of a counter that steps either upward or downward through the values 0 to 9. A direction input picks the sense of counting. An active-low enable freezes the digit. An active-low load forces the digit to a 4-bit value at once. The counter runs on the system clock. It advances one step on each low-to-high transition of a separate count-pulse input, and that transition is detected on the clock.

Two outputs support multi-digit counters. A terminal flag marks the last value in the current direction: 9 when counting up, 0 when counting down. An active-low ripple output follows that flag while the count pulse is low. Feeding the ripple output of a lower digit into the count-pulse input of the next higher digit builds a multi-digit counter. For example, a down count borrows from 20 to 19.

Top module: `bcd_updown_decade`

## Requirements
- R1: While `rst_n` is low and after its release, with `load_n` high, the count reads 0 and `ripple_n` is high.
- R2: While `load_n` is 0, `q` equals `din` in the same cycle, with `din[3]` the most significant bit. Load overrides enable and count pulses. After release, the loaded value stays until the next count event.
- R3: While `en_n` is 1, count events leave `q` unchanged.
- R4: A count event is a 0-to-1 transition of `cp` seen at a clock edge. Holding `cp` high gives exactly one step.
- R5: With `down` = 0, each event adds one to the count, and 9 wraps to 0.
- R6: With `down` = 1, each event subtracts one from the count, and 0 wraps to 9.
- R7: A loaded value of 10 to 15 steps by modulo-16 arithmetic. Counting up from 15 gives 0, and counting down from 10 gives 9.
- R8: `term` is 1 exactly when `q` = 9 with `down` = 0, or when `q` = 0 with `down` = 1.
- R9: `ripple_n` is 0 only while `term` is 1 and the registered level of `cp` is 0.
- R10: With two digits chained, lower `ripple_n` driving upper `cp`, a down step from 20 gives 19 two clocks after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en_n | input | 1 | Active-low count enable |
| down | input | 1 | 1 counts down, 0 counts up |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Load value, bit 3 is the MSB |
| cp | input | 1 | Count-pulse level |
| q | output | 4 | Current digit |
| term | output | 1 | Terminal value for the current direction |
| ripple_n | output | 1 | Active-low chaining output |

## Verification
A load appears on `q` and `term` combinationally. The bench therefore checks it one time unit after driving `load_n`, before any clock edge. A count event lands on the first rising clock edge after `cp` rises, so each step result is sampled on the following falling edge. `ripple_n` depends on the registered `cp` level and changes at that same edge. In the chained pair the borrow needs one more edge: the lower ripple has to register in the upper digit before the upper digit steps. The cascade result is therefore read two falling edges after the pulse.

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade #(
  parameter int unsigned TOP = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       down,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       cp,
  output logic [3:0] q,
  output logic       term,
  output logic       ripple_n
);
  localparam logic [3:0] TOPV = 4'(TOP);

  logic [3:0] cnt, nxt;
  logic       cp_q, step;

  assign step = cp & ~cp_q & ~en_n;

  always_comb begin
    if (down) nxt = (cnt == 4'd0) ? TOPV : cnt - 4'd1;
    else      nxt = (cnt == TOPV) ? 4'd0 : cnt + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 4'd0;
      cp_q <= 1'b0;
    end else begin
      cp_q <= cp;
      if (!load_n)   cnt <= din;
      else if (step) cnt <= nxt;
    end
  end

  assign q        = load_n ? cnt : din;
  assign term     = down ? (q == 4'd0) : (q == TOPV);
  assign ripple_n = ~(term & ~cp_q);

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (cnt == $past(din)));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && load_n) |=> $stable(cnt));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_q && load_n) |=> $stable(cnt));

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !down && step && cnt == TOPV) |=> (cnt == 4'd0));

  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && down && step && cnt == 4'd0) |=> (cnt == TOPV));

  // R9
  ripple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ripple_n |-> (term && !cp_q));
endmodule

// File: tb/tb_bcd_updown_decade.sv
module tb_bcd_updown_decade;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, down = 1'b0, load_n = 1'b1, cp = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic term, ripple_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_updown_decade dut (.clk(clk), .rst_n(rst_n), .en_n(en_n), .down(down),
    .load_n(load_n), .din(din), .cp(cp), .q(q), .term(term), .ripple_n(ripple_n));

  logic lo_load_n = 1'b1, hi_load_n = 1'b1, lo_cp = 1'b0;
  logic [3:0] lo_din = 4'd0, hi_din = 4'd0, lo_q, hi_q;
  logic lo_term, hi_term, lo_rip, hi_rip;

  bcd_updown_decade lo_u (.clk(clk), .rst_n(rst_n), .en_n(1'b0), .down(1'b1),
    .load_n(lo_load_n), .din(lo_din), .cp(lo_cp), .q(lo_q), .term(lo_term), .ripple_n(lo_rip));
  bcd_updown_decade hi_u (.clk(clk), .rst_n(rst_n), .en_n(1'b0), .down(1'b1),
    .load_n(hi_load_n), .din(hi_din), .cp(lo_rip), .q(hi_q), .term(hi_term), .ripple_n(hi_rip));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {load_n, en_n, down, pulse, din[3:0], exp_q[3:0], exp_term}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0101, 4'd7,  4'd7,  1'b0},  // R2 load 7
    {4'b1001, 4'd0,  4'd8,  1'b0},  // R5
    {4'b1001, 4'd0,  4'd9,  1'b1},  // R5 R8
    {4'b1001, 4'd0,  4'd0,  1'b0},  // R5 wrap
    {4'b1101, 4'd0,  4'd0,  1'b0},  // R3 hold
    {4'b1011, 4'd0,  4'd9,  1'b0},  // R6 wrap
    {4'b1011, 4'd0,  4'd8,  1'b0},  // R6
    {4'b0011, 4'd1,  4'd1,  1'b0},  // R2 load under pulse
    {4'b1011, 4'd0,  4'd0,  1'b1},  // R6 R8
    {4'b1011, 4'd0,  4'd9,  1'b0},  // R6 wrap
    {4'b0100, 4'd12, 4'd12, 1'b0},  // R2 R7
    {4'b1001, 4'd0,  4'd13, 1'b0},  // R7
    {4'b0100, 4'd15, 4'd15, 1'b0},  // R7
    {4'b1001, 4'd0,  4'd0,  1'b0},  // R7 mod16
    {4'b0110, 4'd10, 4'd10, 1'b0},  // R7
    {4'b1011, 4'd0,  4'd9,  1'b0},  // R7 down
    {4'b0101, 4'd9,  4'd9,  1'b1}   // R2 R8
  };

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1 q in reset", q, 0);
    chk("R1 ripple_n in reset", ripple_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q after reset", q, 0);

    for (int i = 0; i < NV; i++) begin
      load_n = VEC[i][12]; en_n = VEC[i][11]; down = VEC[i][10];
      cp = VEC[i][9]; din = VEC[i][8:5];
      @(posedge clk); @(negedge clk);
      chk($sformatf("R2-R8 vec%0d q", i), q, VEC[i][4:1]);
      chk($sformatf("R8 vec%0d term", i), term, VEC[i][0]);
      cp = 1'b0; load_n = 1'b1;
      @(posedge clk); @(negedge clk);
    end

    // R2 immediate load, before any edge
    en_n = 1'b0; down = 1'b0; din = 4'd5; load_n = 1'b0;
    #1 chk("R2 immediate", q, 5);
    @(negedge clk); load_n = 1'b1;
    @(negedge clk);

    // R4 hold cp high several clocks: one step
    cp = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 single step", q, 6);
    cp = 1'b0;
    @(negedge clk);

    // R9 ripple with term and cp low
    din = 4'd9; load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    chk("R9 ripple low", ripple_n, 0);
    cp = 1'b1; en_n = 1'b1;
    @(negedge clk);
    chk("R9 ripple high with cp high", ripple_n, 1);
    chk("R3 hold at 9", q, 9);
    cp = 1'b0;
    @(negedge clk);
    down = 1'b1;
    #1 chk("R9 ripple high without term", ripple_n, 1);
    chk("R8 term down at 9", term, 0);

    // R10 cascade borrow 20 -> 19
    lo_din = 4'd0; hi_din = 4'd2; lo_load_n = 1'b0; hi_load_n = 1'b0;
    @(negedge clk); lo_load_n = 1'b1; hi_load_n = 1'b1;
    @(negedge clk);
    chk("R10 before tens", hi_q, 2);
    lo_cp = 1'b1;
    @(negedge clk);
    chk("R10 units", lo_q, 9);
    @(negedge clk);
    chk("R10 tens", hi_q, 1);
    lo_cp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 stays 19", {hi_q, lo_q}, 8'h19);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule